// File: doc/BRIEF.md
# Memory Controller Address Range Filter

This block sits on the request path of a memory controller and decides, for every CPU bus request, whether the access goes to main memory or to the device side. The device side covers two things: anything issued in port space, and any memory-space address that falls inside a window declared as non-memory. Those windows are held in a small set of range registers. Each register stores an inclusive base, an inclusive limit and an enable bit.

Boot firmware loads the range registers through a configuration write port while an unlock input is high. It then drops the unlock, and the windows stay frozen for normal traffic. Out of reset, one window already covers the legacy device buffer area from 0xA0000 to 0xFFFFF. Each accepted request is held in a one-entry register stage behind a valid/ready pair. Its routing is decoded combinationally from that register. A request sent to the device side is also tagged uncacheable, so repeated polls of a device status word always reach the device.

Top module: `addr_range_filter`

## Requirements
- R1: After reset, range 0 is enabled with base 0xA0000 and limit 0xFFFFF, and every other range is disabled. Memory-space addresses 0xA0000 and 0xFFFFF route to the device side. Addresses 0x9FFFF and 0x100000 route to memory.
- R2: A range matches a memory-space address when its enable bit is 1 and base ≤ address ≤ limit, with both bounds inclusive. A range whose enable bit is 0 never matches.
- R3: A memory-space request (req_port_i = 0) that matches no range drives mem_sel_o = 1, dev_sel_o = 0 and uncache_o = 0.
- R4: A port-space request (req_port_i = 1) always drives dev_sel_o = 1, whatever the range registers hold. It presents the low 16 bits of its address on tgt_addr_o with the upper bits zero. A memory-space request presents its full address.
- R5: uncache_o is 1 exactly when tgt_valid_o is 1 and the request is routed to the device side.
- R6: While tgt_valid_o is 1, exactly one of mem_sel_o and dev_sel_o is 1. While tgt_valid_o is 0, both are 0.
- R7: A range programmed with base greater than limit matches no address, even when it is enabled.
- R8: Ranges may overlap. A single matching range is enough to route an access to the device side.
- R9: A configuration write (cfg_we_i = 1) loads entry cfg_idx_i with {cfg_en_i, cfg_base_i, cfg_limit_i} only when cfg_unlock_i = 1. The new values take effect from the next cycle. A write made while cfg_unlock_i = 0 has no effect.
- R10: req_ready_o = !tgt_valid_o || tgt_ready_i. A request accepted on a clock edge appears on the tgt_* outputs from that edge on, with its read and write strobes. It stays unchanged there while tgt_ready_i = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_unlock_i | input | 1 | Allows range register writes while high |
| cfg_we_i | input | 1 | Range register write strobe |
| cfg_idx_i | input | IDX_W (2) | Range entry to write |
| cfg_en_i | input | 1 | Enable bit to write |
| cfg_base_i | input | ADDR_W (32) | Inclusive base to write |
| cfg_limit_i | input | ADDR_W (32) | Inclusive limit to write |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | ADDR_W (32) | Request address |
| req_rd_i | input | 1 | Read strobe |
| req_wr_i | input | 1 | Write strobe |
| req_port_i | input | 1 | 1 = port space, 0 = memory space |
| tgt_valid_o | output | 1 | Routed request valid |
| tgt_ready_i | input | 1 | Downstream accepts routed request |
| tgt_addr_o | output | ADDR_W (32) | Routed address |
| tgt_rd_o | output | 1 | Routed read strobe |
| tgt_wr_o | output | 1 | Routed write strobe |
| mem_sel_o | output | 1 | Route to main memory |
| dev_sel_o | output | 1 | Route to device side |
| uncache_o | output | 1 | Access must bypass caches |

## Verification
The checks on held requests assume tgt_ready_i reflects a real downstream. A request stalled by tgt_ready_i = 0 is then expected to stay unchanged on the outputs. The held-output check also assumes the range registers are not rewritten while a request waits. The bench keeps to this by changing range contents only while no request is outstanding. It drives backpressure only in a directed sequence that has no configuration traffic. Random traffic aims addresses at the bounds of the programmed windows and just beyond them. Random windows include reversed ones and overlapping ones.

// File: rtl/arf_pkg.sv
package arf_pkg;
  localparam int ADDR_W = 32;
  localparam int PORT_W = 16;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
  } range_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              wr;
    logic              port;
  } req_t;

  localparam logic [ADDR_W-1:0] LEGACY_BASE  = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] LEGACY_LIMIT = 32'h000F_FFFF;

  function automatic range_t reset_range(input int idx);
    range_t r;
    r.en    = (idx == 0);
    r.base  = (idx == 0) ? LEGACY_BASE  : '0;
    r.limit = (idx == 0) ? LEGACY_LIMIT : '0;
    return r;
  endfunction
endpackage

// File: rtl/arf_range_regs.sv
module arf_range_regs
  import arf_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        unlock_i,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  range_t                      wdata_i,
  output range_t [NUM_RANGES-1:0]     ranges_o
);
  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ranges_o[g] <= reset_range(g);
      end else if (we_i && unlock_i && (int'(idx_i) == g)) begin
        ranges_o[g] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/arf_range_match.sv
module arf_range_match
  import arf_pkg::*;
#(
  parameter int NUM_RANGES = 4
) (
  input  range_t [NUM_RANGES-1:0] ranges_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [NUM_RANGES-1:0]   hit_vec_o,
  output logic                    hit_o
);
  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
    logic ge_base, le_limit;
    assign ge_base  = (addr_i >= ranges_i[g].base);
    assign le_limit = (addr_i <= ranges_i[g].limit);
    // reversed bounds can never satisfy both compares
    assign hit_vec_o[g] = ranges_i[g].en & ge_base & le_limit;
  end
  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/arf_req_stage.sv
module arf_req_stage
  import arf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic in_ready_o,
  input  req_t in_req_i,
  output logic out_valid_o,
  input  logic out_ready_i,
  output req_t out_req_o
);
  logic load;
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign load       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_req_o   <= '0;
    end else if (load) begin
      out_valid_o <= 1'b1;
      out_req_o   <= in_req_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_range_filter.sv
module addr_range_filter
  import arf_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_unlock_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_limit_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_rd_i,
  input  logic              req_wr_i,
  input  logic              req_port_i,
  output logic              tgt_valid_o,
  input  logic              tgt_ready_i,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic              tgt_rd_o,
  output logic              tgt_wr_o,
  output logic              mem_sel_o,
  output logic              dev_sel_o,
  output logic              uncache_o
);
  range_t [NUM_RANGES-1:0] ranges;
  range_t                  cfg_wdata;
  req_t                    in_req, held_req;
  logic [NUM_RANGES-1:0]   hit_vec;
  logic                    range_hit;
  logic                    dev_route;

  assign cfg_wdata = '{en: cfg_en_i, base: cfg_base_i, limit: cfg_limit_i};
  assign in_req    = '{addr: req_addr_i, rd: req_rd_i, wr: req_wr_i, port: req_port_i};

  arf_range_regs #(.NUM_RANGES(NUM_RANGES)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .unlock_i (cfg_unlock_i),
    .we_i     (cfg_we_i),
    .idx_i    (cfg_idx_i),
    .wdata_i  (cfg_wdata),
    .ranges_o (ranges)
  );

  arf_req_stage u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_req_i    (in_req),
    .out_valid_o (tgt_valid_o),
    .out_ready_i (tgt_ready_i),
    .out_req_o   (held_req)
  );

  arf_range_match #(.NUM_RANGES(NUM_RANGES)) u_match (
    .ranges_i  (ranges),
    .addr_i    (held_req.addr),
    .hit_vec_o (hit_vec),
    .hit_o     (range_hit)
  );

  // port space bypasses the range check entirely
  assign dev_route  = held_req.port | range_hit;
  assign mem_sel_o  = tgt_valid_o & ~dev_route;
  assign dev_sel_o  = tgt_valid_o &  dev_route;
  assign uncache_o  = tgt_valid_o &  dev_route;
  assign tgt_rd_o   = held_req.rd;
  assign tgt_wr_o   = held_req.wr;
  assign tgt_addr_o = held_req.port
                    ? {{(ADDR_W-PORT_W){1'b0}}, held_req.addr[PORT_W-1:0]}
                    : held_req.addr;
endmodule

// File: rtl/arf_checker.sv
module arf_checker
  import arf_pkg::*;
#(
  parameter int NUM_RANGES = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cfg_unlock_i,
  input logic                    tgt_valid_o,
  input logic                    tgt_ready_i,
  input logic                    req_ready_o,
  input logic [ADDR_W-1:0]       tgt_addr_o,
  input logic                    mem_sel_o,
  input logic                    dev_sel_o,
  input logic                    uncache_o,
  input logic                    held_port,
  input logic                    range_hit,
  input range_t [NUM_RANGES-1:0] ranges
);
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> ($countones({mem_sel_o, dev_sel_o}) == 1)); // R6
  AST_IDLE_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_valid_o |-> !mem_sel_o && !dev_sel_o && !uncache_o); // R6
  AST_PORT_TO_DEV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o && held_port |-> dev_sel_o); // R4
  AST_HIT_UNCACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o && (held_port || range_hit) |-> uncache_o); // R5
  AST_MISS_CACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o && !held_port && !range_hit |-> mem_sel_o && !uncache_o); // R3
  AST_LOCKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_unlock_i |=> $stable(ranges)); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o && !tgt_ready_i |=> tgt_valid_o && $stable(tgt_addr_o)); // R10
  AST_READY_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o && !tgt_ready_i |-> !req_ready_o); // R10
endmodule

bind addr_range_filter arf_checker #(.NUM_RANGES(NUM_RANGES)) u_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_unlock_i (cfg_unlock_i),
  .tgt_valid_o  (tgt_valid_o),
  .tgt_ready_i  (tgt_ready_i),
  .req_ready_o  (req_ready_o),
  .tgt_addr_o   (tgt_addr_o),
  .mem_sel_o    (mem_sel_o),
  .dev_sel_o    (dev_sel_o),
  .uncache_o    (uncache_o),
  .held_port    (held_req.port),
  .range_hit    (range_hit),
  .ranges       (ranges)
);

// File: tb/addr_range_filter_bench.sv
module addr_range_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_unlock = 1'b1, cfg_we = 1'b0, cfg_en = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0, cfg_limit = '0;
  logic        req_valid = 1'b0, req_rd = 1'b0, req_wr = 1'b0, req_port = 1'b0;
  logic [31:0] req_addr = '0;
  logic        tgt_ready = 1'b1;
  logic        req_ready, tgt_valid, tgt_rd, tgt_wr, mem_sel, dev_sel, uncache;
  logic [31:0] tgt_addr;

  int checks = 0, failures = 0;
  logic        m_en [NR];
  logic [31:0] m_base [NR], m_limit [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_range_filter u_addr_range_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_unlock_i(cfg_unlock), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_en_i(cfg_en), .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_rd_i(req_rd), .req_wr_i(req_wr), .req_port_i(req_port),
    .tgt_valid_o(tgt_valid), .tgt_ready_i(tgt_ready), .tgt_addr_o(tgt_addr),
    .tgt_rd_o(tgt_rd), .tgt_wr_o(tgt_wr), .mem_sel_o(mem_sel),
    .dev_sel_o(dev_sel), .uncache_o(uncache)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_dev(input logic [31:0] a, input logic port);
    logic d = port;
    for (int i = 0; i < NR; i++)
      if (m_en[i] && m_base[i] <= a && a <= m_limit[i]) d = 1'b1;
    return d;
  endfunction

  task automatic cfg_write(input int idx, input logic en, input logic [31:0] b,
                           input logic [31:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_en = en; cfg_base = b; cfg_limit = l;
    if (cfg_unlock) begin m_en[idx] = en; m_base[idx] = b; m_limit[idx] = l; end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive at negedge, captured at posedge, checked at following negedge
  task automatic send(input string req, input logic [31:0] a, input logic port,
                      input logic rd, input logic wr);
    logic d;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_port = port; req_rd = rd; req_wr = wr;
    @(negedge clk);
    req_valid = 1'b0;
    d = exp_dev(a, port);
    check({req, " valid"}, 64'(tgt_valid), 64'd1);
    check({req, " dev_sel"}, 64'(dev_sel), 64'(d));
    check({req, " mem_sel"}, 64'(mem_sel), 64'(!d));
    check({req, " uncache"}, 64'(uncache), 64'(d));
    check({req, " addr"}, 64'(tgt_addr), 64'(port ? {16'h0, a[15:0]} : a));
    check({req, " strobes"}, 64'({tgt_rd, tgt_wr}), 64'({rd, wr}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) begin
      m_en[i] = (i == 0); m_base[i] = (i == 0) ? 32'hA0000 : 0;
      m_limit[i] = (i == 0) ? 32'hFFFFF : 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 R10: idle after reset
    check("R6 reset no sel", 64'({tgt_valid, mem_sel, dev_sel, uncache}), 64'd0);
    check("R10 reset ready", 64'(req_ready), 64'd1);

    // R1 default legacy window bounds
    send("R1 A0000", 32'hA0000, 1'b0, 1'b1, 1'b0);
    send("R1 FFFFF", 32'hFFFFF, 1'b0, 1'b0, 1'b1);
    send("R1 9FFFF", 32'h9FFFF, 1'b0, 1'b1, 1'b0);
    send("R1 100000", 32'h100000, 1'b0, 1'b1, 1'b0);
    // R3 plain memory
    send("R3 mem low", 32'h1000, 1'b0, 1'b1, 1'b0);
    // R4 port space with upper bits set, outside every window
    send("R4 port", 32'hDEAD_1234, 1'b1, 1'b0, 1'b1);
    send("R4 port low", 32'h0000_0004, 1'b1, 1'b1, 1'b0);

    // R2 R8 overlapping windows, R7 reversed window
    cfg_write(1, 1'b1, 32'h8000_0000, 32'h8000_FFFF);
    cfg_write(2, 1'b1, 32'h8000_8000, 32'h8001_0000);
    cfg_write(3, 1'b1, 32'h4000_0100, 32'h4000_0000);
    send("R8 overlap both", 32'h8000_9000, 1'b0, 1'b1, 1'b0);
    send("R8 only second", 32'h8001_0000, 1'b0, 1'b1, 1'b0);
    send("R2 just past", 32'h8001_0001, 1'b0, 1'b1, 1'b0);
    send("R7 reversed mid", 32'h4000_0080, 1'b0, 1'b1, 1'b0);
    send("R7 reversed base", 32'h4000_0100, 1'b0, 1'b1, 1'b0);
    check("R7 reversed is mem", 64'(mem_sel), 64'd1);
    cfg_write(1, 1'b0, 32'h8000_0000, 32'h8000_FFFF);
    send("R2 disabled", 32'h8000_0010, 1'b0, 1'b1, 1'b0);
    check("R2 disabled goes mem", 64'(mem_sel), 64'd1);

    // R10 backpressure
    @(negedge clk);
    tgt_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h2222; req_port = 1'b0; req_rd = 1'b1; req_wr = 1'b0;
    @(negedge clk);
    check("R10 held valid", 64'(tgt_valid), 64'd1);
    check("R10 ready low", 64'(req_ready), 64'd0);
    req_addr = 32'hA1234;
    @(negedge clk);
    check("R10 held addr", 64'(tgt_addr), 64'h2222);
    check("R10 held mem", 64'(mem_sel), 64'd1);
    tgt_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 next addr", 64'(tgt_addr), 64'hA1234);
    check("R10 next dev", 64'(dev_sel), 64'd1);
    @(negedge clk);
    check("R10 drained", 64'(tgt_valid), 64'd0);

    // random windows and traffic
    for (int it = 0; it < 40; it++) begin
      for (int r = 0; r < NR; r++) begin
        logic [31:0] b, l;
        b = $urandom() & 32'h000F_FFF0;
        l = b + (($urandom() & 32'h3FFF) - 32'h800);
        cfg_write(r, 1'($urandom()), b, l);
      end
      for (int k = 0; k < 12; k++) begin
        int r;
        logic [31:0] a;
        r = $urandom_range(NR-1);
        case ($urandom_range(3))
          0: a = m_base[r];
          1: a = m_limit[r];
          2: a = m_limit[r] + 1;
          default: a = m_base[r] - 1;
        endcase
        send("R2 random", a, 1'($urandom_range(7) == 0), 1'($urandom()), 1'($urandom()));
      end
    end

    // R9 lock: writes ignored
    cfg_write(0, 1'b1, 32'hA0000, 32'hFFFFF);
    cfg_write(1, 1'b0, 32'h0, 32'h0);
    cfg_write(2, 1'b0, 32'h0, 32'h0);
    cfg_write(3, 1'b0, 32'h0, 32'h0);
    cfg_unlock = 1'b0;
    cfg_write(0, 1'b0, 32'h0, 32'h0);
    cfg_write(1, 1'b1, 32'h0, 32'hFFFF_FFFF);
    send("R9 locked keep", 32'hB8000, 1'b0, 1'b1, 1'b0);
    check("R9 locked dev", 64'(dev_sel), 64'd1);
    send("R9 locked no new", 32'h0020_0000, 1'b0, 1'b1, 1'b0);
    check("R9 locked mem", 64'(mem_sel), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule